// File: doc/BRIEF.md
# Scaler Phase Generator

This block sets up the phase arithmetic for a polyphase scaler that works on one layer at a time. A start pulse carries a layer-select mask and the source and destination sizes of the layer. The block screens the request and then divides to get a phase step and a starting phase for each axis. It also decides whether the upscale sharpening stage should be switched on. After one done pulse it walks the destination frame in raster order. For every output pixel it gives the integer source position and the 4-bit filter phase on each axis.

The controller has four states. ST_IDLE waits for start. An accepted, valid request goes from there to ST_DIVIDE. A rejected request, or one with nothing to scale, goes straight to ST_SETTLE. ST_DIVIDE runs two serial dividers, one for each axis, side by side, and moves to ST_SETTLE when both finish. ST_SETTLE lasts one cycle and drives the done pulse. From there the block moves to ST_STREAM when scaling is enabled and to ST_IDLE otherwise. ST_STREAM goes back to ST_IDLE after the last pixel of the frame.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, busy, done, err, scale_en, enh_en and pix_valid are 0, and all phase outputs are 0.
- R2: For a valid request, h_step equals floor(in_w·65536 / out_w) and v_step equals floor(in_h·65536 / out_h). Both are valid while done is high.
- R3: h_init equals (floor(in_w·16 / out_w) + 1) / 2 with truncating division, and v_init follows the same rule with heights. Both are valid while done is high.
- R4: enh_en is 1 exactly when out_w ≥ 2·in_w or out_h ≥ 2·in_h. This is the point where the integer part of the 16.16 upscale ratio reaches 2.
- R5: A layer_mask with two or more bits set gives err=1, scale_en=0, one done pulse, zero phase outputs and no pixels.
- R6: An all-zero layer_mask gives err=0, scale_en=0, one done pulse and no pixels.
- R7: With exactly one mask bit set, a zero in any of in_w, in_h, out_w or out_h gives err=1, scale_en=0, one done pulse and no pixels. A later valid request clears err.
- R8: After done for a valid request, exactly out_w·out_h pixels follow in raster order with x changing fastest, one on every cycle. pix_eol marks the last pixel of each row and pix_eof marks the last pixel of the frame.
- R9: For output pixel (x, y), let A = h_init·4096 + x·h_step. Then pix_x_src = A >> 16 and pix_x_phase = bits 15..12 of A. The y axis uses v_init and v_step in the same way.
- R10: A start pulse while busy is high is ignored. The results and the pixel stream of the running request are unchanged.
- R11: done is high for exactly one cycle per accepted start. busy is high from that acceptance until the last pixel, or until the done cycle when no pixels follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| layer_mask | input | LAYERS | One bit per layer asking to be scaled |
| in_w | input | DIM_W | Source width in pixels |
| in_h | input | DIM_W | Source height in pixels |
| out_w | input | DIM_W | Destination width in pixels |
| out_h | input | DIM_W | Destination height in pixels |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| err | output | 1 | Last request was rejected |
| scale_en | output | 1 | Last request enables scaling |
| enh_en | output | 1 | Upscale sharpening enable |
| h_init | output | DIM_W+4 | Horizontal starting phase, in 1/16 pixel |
| h_step | output | DIM_W+16 | Horizontal phase step, 16 fractional bits |
| v_init | output | DIM_W+4 | Vertical starting phase, in 1/16 pixel |
| v_step | output | DIM_W+16 | Vertical phase step, 16 fractional bits |
| pix_valid | output | 1 | Pixel fields are valid |
| pix_x_src | output | DIM_W+1 | Horizontal source index |
| pix_x_phase | output | 4 | Horizontal filter phase |
| pix_y_src | output | DIM_W+1 | Vertical source index |
| pix_y_phase | output | 4 | Vertical filter phase |
| pix_eol | output | 1 | Last pixel of a row |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The assertions check on every cycle that done lasts one cycle and that nothing streams while the block is idle, in error or with scaling off. They also check that the stream has no gaps until the frame ends, that an end-of-frame marker always comes with an end-of-row marker, and that the steps stay fixed while pixels flow. Only the bench scenarios can show the arithmetic. This covers the exact step and starting phase of each axis, the sharpening threshold at exactly double size, each source index and phase, the pixel count of a frame, and the fact that a start pulse given mid-run leaves those results untouched.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int PHASE_BITS = 4;
    localparam int STEP_FRAC  = 16;
    localparam int INIT_SHIFT = STEP_FRAC - PHASE_BITS;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SETTLE = 2'd2,
        ST_STREAM = 2'd3
    } scl_state_t;

endpackage

// File: rtl/scl_seq_div.sv
module scl_seq_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] qn_q;

    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   trial_sub;

    always_comb begin
        trial     = {rem_q, qn_q[NUM_W-1]};
        fits      = trial >= {1'b0, den_q};
        trial_sub = fits ? (trial - {1'b0, den_q}) : trial;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            rem_q  <= '0;
            den_q  <= '0;
            qn_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                qn_q  <= num;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= trial_sub[DEN_W-1:0];
                qn_q  <= {qn_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = qn_q;

endmodule

// File: rtl/scl_raster_walk.sv
module scl_raster_walk
    import scl_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [DIM_W-1:0]            width,
    input  logic [DIM_W-1:0]            height,
    input  logic [DIM_W+PHASE_BITS-1:0] h_init,
    input  logic [DIM_W+STEP_FRAC-1:0]  h_step,
    input  logic [DIM_W+PHASE_BITS-1:0] v_init,
    input  logic [DIM_W+STEP_FRAC-1:0]  v_step,
    output logic                        valid,
    output logic [DIM_W:0]              x_src,
    output logic [PHASE_BITS-1:0]       x_phase,
    output logic [DIM_W:0]              y_src,
    output logic [PHASE_BITS-1:0]       y_phase,
    output logic                        eol,
    output logic                        eof
);
    localparam int INIT_W = DIM_W + PHASE_BITS;
    localparam int ACC_W  = DIM_W + STEP_FRAC + 1;
    localparam int PAD_W  = ACC_W - INIT_W - INIT_SHIFT;

    logic             active_q;
    logic [DIM_W-1:0] xc_q;
    logic [DIM_W-1:0] yc_q;
    logic [ACC_W-1:0] hacc_q;
    logic [ACC_W-1:0] vacc_q;

    logic [ACC_W-1:0] h_start;
    logic [ACC_W-1:0] v_start;
    logic [DIM_W-1:0] w_last;
    logic [DIM_W-1:0] h_last;

    always_comb begin
        h_start = {{PAD_W{1'b0}}, h_init, {INIT_SHIFT{1'b0}}};
        v_start = {{PAD_W{1'b0}}, v_init, {INIT_SHIFT{1'b0}}};
        w_last  = width - 1'b1;
        h_last  = height - 1'b1;
    end

    assign valid   = active_q;
    assign x_src   = hacc_q[ACC_W-1:STEP_FRAC];
    assign x_phase = hacc_q[STEP_FRAC-1 -: PHASE_BITS];
    assign y_src   = vacc_q[ACC_W-1:STEP_FRAC];
    assign y_phase = vacc_q[STEP_FRAC-1 -: PHASE_BITS];
    assign eol     = active_q && (xc_q == w_last);
    assign eof     = eol && (yc_q == h_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            xc_q     <= '0;
            yc_q     <= '0;
            hacc_q   <= '0;
            vacc_q   <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            xc_q     <= '0;
            yc_q     <= '0;
            hacc_q   <= h_start;
            vacc_q   <= v_start;
        end else if (active_q) begin
            if (eof) begin
                active_q <= 1'b0;
            end else if (eol) begin
                xc_q   <= '0;
                yc_q   <= yc_q + 1'b1;
                hacc_q <= h_start;
                vacc_q <= vacc_q + {1'b0, v_step};
            end else begin
                xc_q   <= xc_q + 1'b1;
                hacc_q <= hacc_q + {1'b0, h_step};
            end
        end
    end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int LAYERS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [LAYERS-1:0]           layer_mask,
    input  logic [DIM_W-1:0]            in_w,
    input  logic [DIM_W-1:0]            in_h,
    input  logic [DIM_W-1:0]            out_w,
    input  logic [DIM_W-1:0]            out_h,
    output logic                        busy,
    output logic                        done,
    output logic                        err,
    output logic                        scale_en,
    output logic                        enh_en,
    output logic [DIM_W+PHASE_BITS-1:0] h_init,
    output logic [DIM_W+STEP_FRAC-1:0]  h_step,
    output logic [DIM_W+PHASE_BITS-1:0] v_init,
    output logic [DIM_W+STEP_FRAC-1:0]  v_step,
    output logic                        pix_valid,
    output logic [DIM_W:0]              pix_x_src,
    output logic [PHASE_BITS-1:0]       pix_x_phase,
    output logic [DIM_W:0]              pix_y_src,
    output logic [PHASE_BITS-1:0]       pix_y_phase,
    output logic                        pix_eol,
    output logic                        pix_eof
);
    localparam int NUM_W  = DIM_W + STEP_FRAC;
    localparam int INIT_W = DIM_W + PHASE_BITS;
    localparam int LANES  = 2;

    scl_state_t state_q, state_d;

    logic [DIM_W-1:0]  iw_q, ih_q, ow_q, oh_q;
    logic              err_q, scale_q, enh_q;
    logic [INIT_W-1:0] h_init_q, v_init_q;
    logic [NUM_W-1:0]  h_step_q, v_step_q;

    logic              sel_many, sel_none, dim_zero, accept_ok;
    logic              div_go, all_done, walk_go, walk_last;
    logic              enh_calc;

    logic [NUM_W-1:0]  div_num  [LANES];
    logic [DIM_W-1:0]  div_den  [LANES];
    logic [NUM_W-1:0]  div_quo  [LANES];
    logic [INIT_W-1:0] init_val [LANES];
    logic [LANES-1:0]  div_done;

    // request screening
    always_comb begin
        sel_many  = $countones(layer_mask) > 1;
        sel_none  = (layer_mask == '0);
        dim_zero  = (in_w == '0) || (in_h == '0) || (out_w == '0) || (out_h == '0);
        accept_ok = !sel_many && !sel_none && !dim_zero;
        div_go    = (state_q == ST_IDLE) && start && accept_ok;
        all_done  = &div_done;
        enh_calc  = ({1'b0, ow_q} >= {iw_q, 1'b0}) || ({1'b0, oh_q} >= {ih_q, 1'b0});
        walk_go   = (state_q == ST_SETTLE) && scale_q;
    end

    assign div_num[0] = {in_w, {STEP_FRAC{1'b0}}};
    assign div_num[1] = {in_h, {STEP_FRAC{1'b0}}};
    assign div_den[0] = out_w;
    assign div_den[1] = out_h;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        scl_seq_div #(
            .NUM_W(NUM_W),
            .DEN_W(DIM_W)
        ) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .start(div_go),
            .num  (div_num[g]),
            .den  (div_den[g]),
            .done (div_done[g]),
            .quo  (div_quo[g])
        );
        // (q/4096 + 1)/2 folded as q/8192 plus the rounding bit
        assign init_val[g] = INIT_W'(div_quo[g][NUM_W-1:INIT_SHIFT+1])
                           + INIT_W'(div_quo[g][INIT_SHIFT]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = accept_ok ? ST_DIVIDE : ST_SETTLE;
            ST_DIVIDE: if (all_done) state_d = ST_SETTLE;
            ST_SETTLE: state_d = scale_q ? ST_STREAM : ST_IDLE;
            ST_STREAM: if (walk_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iw_q     <= '0;
            ih_q     <= '0;
            ow_q     <= '0;
            oh_q     <= '0;
            err_q    <= 1'b0;
            scale_q  <= 1'b0;
            enh_q    <= 1'b0;
            h_init_q <= '0;
            v_init_q <= '0;
            h_step_q <= '0;
            v_step_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        iw_q     <= in_w;
                        ih_q     <= in_h;
                        ow_q     <= out_w;
                        oh_q     <= out_h;
                        err_q    <= sel_many || (!sel_none && dim_zero);
                        scale_q  <= accept_ok;
                        enh_q    <= 1'b0;
                        h_init_q <= '0;
                        v_init_q <= '0;
                        h_step_q <= '0;
                        v_step_q <= '0;
                    end
                end
                ST_DIVIDE: begin
                    if (all_done) begin
                        h_step_q <= div_quo[0];
                        v_step_q <= div_quo[1];
                        h_init_q <= init_val[0];
                        v_init_q <= init_val[1];
                        enh_q    <= enh_calc;
                    end
                end
                default: ;
            endcase
        end
    end

    scl_raster_walk #(
        .DIM_W(DIM_W)
    ) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (walk_go),
        .width  (ow_q),
        .height (oh_q),
        .h_init (h_init_q),
        .h_step (h_step_q),
        .v_init (v_init_q),
        .v_step (v_step_q),
        .valid  (pix_valid),
        .x_src  (pix_x_src),
        .x_phase(pix_x_phase),
        .y_src  (pix_y_src),
        .y_phase(pix_y_phase),
        .eol    (pix_eol),
        .eof    (pix_eof)
    );

    assign walk_last = pix_valid && pix_eof;

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_SETTLE);
    assign err      = err_q;
    assign scale_en = scale_q;
    assign enh_en   = enh_q;
    assign h_init   = h_init_q;
    assign v_init   = v_init_q;
    assign h_step   = h_step_q;
    assign v_step   = v_step_q;

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
    parameter int DIM_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              scale_en,
    input logic              enh_en,
    input logic [DIM_W+15:0] h_step,
    input logic [DIM_W+15:0] v_step,
    input logic              pix_valid,
    input logic              pix_eol,
    input logic              pix_eof
);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pix_valid && !done));

    a_r5_err_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !pix_valid);

    a_r6_stream_needs_scale: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> scale_en);

    a_r4_enh_needs_scale: assert property (@(posedge clk) disable iff (!rst_n)
        enh_en |-> scale_en);

    a_r8_eof_has_eol: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eof |-> (pix_eol && pix_valid));

    a_r8_no_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_eof) |=> pix_valid);

    a_r10_steps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_eof) |=> ($stable(h_step) && $stable(v_step)));

endmodule

bind scl_phase_gen scl_phase_gen_chk #(.DIM_W(DIM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .scale_en (scale_en),
    .enh_en   (enh_en),
    .h_step   (h_step),
    .v_step   (v_step),
    .pix_valid(pix_valid),
    .pix_eol  (pix_eol),
    .pix_eof  (pix_eof)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
    localparam int DIM_W  = 12;
    localparam int LAYERS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LAYERS-1:0] layer_mask = '0;
    logic [DIM_W-1:0]  in_w = '0, in_h = '0, out_w = '0, out_h = '0;
    logic              busy, done, err, scale_en, enh_en;
    logic [DIM_W+3:0]  h_init, v_init;
    logic [DIM_W+15:0] h_step, v_step;
    logic              pix_valid, pix_eol, pix_eof;
    logic [DIM_W:0]    pix_x_src, pix_y_src;
    logic [3:0]        pix_x_phase, pix_y_phase;

    int n_tot  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    scl_phase_gen #(.DIM_W(DIM_W), .LAYERS(LAYERS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .layer_mask(layer_mask),
        .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
        .busy(busy), .done(done), .err(err), .scale_en(scale_en), .enh_en(enh_en),
        .h_init(h_init), .h_step(h_step), .v_init(v_init), .v_step(v_step),
        .pix_valid(pix_valid), .pix_x_src(pix_x_src), .pix_x_phase(pix_x_phase),
        .pix_y_src(pix_y_src), .pix_y_phase(pix_y_phase),
        .pix_eol(pix_eol), .pix_eof(pix_eof)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [LAYERS-1:0] m, input int iw, input int ih,
                               input int ow, input int oh);
        @(negedge clk);
        layer_mask = m;
        in_w = DIM_W'(iw); in_h = DIM_W'(ih); out_w = DIM_W'(ow); out_h = DIM_W'(oh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    // checks results and the full pixel stream of a valid request
    task automatic verify(input string tag, input int iw, input int ih,
                          input int ow, input int oh);
        bit     seen;
        longint hs, vs, hi, vi, ha, va;
        int     k, bad, extra_done;
        hs = (longint'(iw) << 16) / ow;
        vs = (longint'(ih) << 16) / oh;
        hi = (((longint'(iw) << 4) / ow) + 1) / 2;
        vi = (((longint'(ih) << 4) / oh) + 1) / 2;
        wait_done(seen);
        chk({tag, " R11 done seen"}, seen, 1);
        chk({tag, " R7 err clear"}, err, 0);
        chk({tag, " R6 scale_en"}, scale_en, 1);
        chk({tag, " R2 h_step"}, h_step, hs);
        chk({tag, " R2 v_step"}, v_step, vs);
        chk({tag, " R3 h_init"}, h_init, hi);
        chk({tag, " R3 v_init"}, v_init, vi);
        chk({tag, " R4 enh_en"}, enh_en, ((ow >= 2*iw) || (oh >= 2*ih)) ? 1 : 0);
        k = 0; bad = 0; extra_done = 0;
        for (int c = 0; c < ow*oh + 20; c++) begin
            @(negedge clk);
            if (done) extra_done++;
            if (pix_valid) begin
                int x, y;
                x  = k % ow;
                y  = k / ow;
                ha = (hi << 12) + longint'(x) * hs;
                va = (vi << 12) + longint'(y) * vs;
                if (pix_x_src != (ha >> 16) || pix_x_phase != ((ha >> 12) & 15) ||
                    pix_y_src != (va >> 16) || pix_y_phase != ((va >> 12) & 15))
                    bad++;
                if (pix_eol != (x == ow - 1)) bad++;
                if (pix_eof != (k == ow*oh - 1)) bad++;
                k++;
                if (pix_eof) break;
            end else if (k > 0) begin
                bad++;
                break;
            end
        end
        chk({tag, " R9 pixel mismatches"}, bad, 0);
        chk({tag, " R8 pixel count"}, k, ow*oh);
        chk({tag, " R11 single done"}, extra_done, 0);
        @(negedge clk);
        chk({tag, " R11 busy drops"}, busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 scale_en", scale_en, 0);
        chk("R1 enh_en", enh_en, 0);
        chk("R1 pix_valid", pix_valid, 0);
        chk("R1 h_step", h_step, 0);
    endtask

    task automatic t_scaled(input string tag, input int iw, input int ih,
                            input int ow, input int oh);
        pulse_start(4'b0010, iw, ih, ow, oh);
        verify(tag, iw, ih, ow, oh);
    endtask

    // rejected or idle request: done once, no stream
    task automatic t_no_stream(input string tag, input logic [LAYERS-1:0] m,
                               input int iw, input int ih, input int ow, input int oh,
                               input int exp_err);
        bit seen;
        int pix;
        pulse_start(m, iw, ih, ow, oh);
        wait_done(seen);
        chk({tag, " done"}, seen, 1);
        chk({tag, " err"}, err, exp_err);
        chk({tag, " scale_en"}, scale_en, 0);
        chk({tag, " phase cleared"}, h_step + v_step + h_init + v_init, 0);
        pix = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (pix_valid) pix++;
        end
        chk({tag, " no pixels"}, pix, 0);
        chk({tag, " idle"}, busy, 0);
    endtask

    task automatic t_start_while_busy();
        pulse_start(4'b0001, 4, 4, 8, 4);
        repeat (3) @(negedge clk);
        layer_mask = 4'b0001;
        in_w = 12; in_h = 12; out_w = 3; out_h = 3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        verify("R10 busy start", 4, 4, 8, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_scaled("up 10x8", 10, 8, 25, 20);
        t_scaled("down 40x6", 40, 6, 16, 6);
        t_scaled("up 3x3", 3, 3, 7, 5);
        t_scaled("R4 exact double", 5, 9, 10, 17);
        t_scaled("R4 below double", 5, 9, 9, 17);
        t_scaled("max source", 4095, 4095, 1, 1);
        t_no_stream("R5 two layers", 4'b0101, 10, 10, 20, 20, 1);
        t_no_stream("R6 no layer", 4'b0000, 10, 10, 20, 20, 0);
        t_no_stream("R7 zero out_w", 4'b1000, 10, 10, 0, 20, 1);
        t_no_stream("R7 zero in_h", 4'b1000, 10, 0, 20, 20, 1);
        t_scaled("R7 recover", 6, 6, 6, 6);
        t_start_while_busy();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule